// File: doc/BRIEF.md
# Phase-Shifted Triangular Carrier Bank

This block produces four triangular carriers for the modulators of one phase of a five-level cascaded inverter, which has two H-bridge cells in series. Every carrier is an up/down counter. It climbs from 0 to a programmable peak P and falls back to 0, so one full carrier period lasts 2P enabled clocks. The four counters share one clock, one enable and one peak value. They are locked a quarter period apart: a 0 and 180 degree pair serves the two legs of the first cell, and the pair shifted by a further 90 degrees serves the second cell. The switches in the same position of the other two phases reuse the same four carriers.

Each counter raises a one-clock strobe when it arrives at zero. Downstream pulse-width logic uses that strobe to move a buffered duty value into its compare register. The bank also raises one interrupt strobe on every quarter of the carrier period, which paces the host that computes new duty values. A new peak value is adopted only when carrier 0 lands on zero. At that point all four counters restart together at the positions that match the new peak, so their relative phases are never broken.

Top module: `carrier_bank`

## Requirements
- R1: While `rst` is high at a rising edge, the bank loads carrier 0 with 0 (rising), carrier 1 with P/2 (rising), carrier 2 with P (falling) and carrier 3 with P/2 (falling), with P taken from `peak`. All zero strobes and the interrupt are low after that edge.
- R2: On each rising edge with `en` high, carrier 0 moves by exactly one count. It rises to P, turns at once and falls to 0, then rises again, so neither endpoint is held for two clocks and one period lasts 2P enabled edges.
- R3: Carrier k always holds the value carrier 0 will hold k*P/2 enabled edges later, which gives offsets of 0, 90, 180 and 270 degrees. As a result, carrier0 + carrier2 equals carrier1 + carrier3 at all times.
- R4: On a rising edge with `en` low, no carrier changes, and every strobe is low after that edge.
- R5: `zero_o[k]` is high for exactly the one clock that follows the edge at which carrier k moved onto 0. At most one zero strobe is high at a time.
- R6: `irq_o` is high for exactly the one clock that follows an edge at which carrier 0 moved onto 0, P/2 or P, in either direction. That makes four pulses per carrier period, each one clock wide.
- R7: A change on `peak` takes effect only at the enabled edge at which carrier 0 steps from 1 down to 0. At that edge all four carriers load the R1 positions for the new peak.
- R8: `peak` is even, at least 4 and at most 2^W-2. Carrier k is output on `carrier_o[k*W +: W]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all four counters |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; the carriers freeze while it is low |
| peak | input | W | Peak count P; sampled at reset and when carrier 0 lands on zero |
| carrier_o | output | 4*W | Four carrier values, carrier k at bits k*W +: W |
| zero_o | output | 4 | One-clock strobe per carrier on arrival at zero |
| irq_o | output | 1 | One-clock strobe on every quarter carrier period |

## Verification
The properties assume that `peak` stays even, at least 4 and below the counter's full range. With a smaller peak, the quarter points would fall on adjacent clocks and the interrupt could be held high. The stimulus therefore uses only even peaks from 4 up to 254, and it changes `peak` both in the middle of a period and just before carrier 0 wraps. `en` is dropped at random cycles, so the properties also see frozen carriers, including stalls that start on a strobe edge. The relation between the four carriers and the points at which the interrupt fires are checked through the output values alone, so the stimulus includes a reset in the middle of a run.

// File: rtl/carrier_bank.sv
module carrier_bank #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [W-1:0]   peak,
  output logic [4*W-1:0] carrier_o,
  output logic [3:0]     zero_o,
  output logic           irq_o
);
  localparam int NC = 4;

  logic [W-1:0] cnt [NC];
  logic [W-1:0] nxt [NC];
  logic [NC-1:0] rising;
  logic [W-1:0] pk;
  logic [W-1:0] half;
  logic         wrap;

  assign half = pk >> 1;
  assign wrap = en && (cnt[0] == W'(1)) && !rising[0];

  for (genvar k = 0; k < NC; k++) begin : g_lane
    assign nxt[k] = rising[k] ? cnt[k] + 1'b1 : cnt[k] - 1'b1;
    assign carrier_o[k*W +: W] = cnt[k];
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      pk        <= peak;
      cnt[0]    <= '0;
      cnt[1]    <= peak >> 1;
      cnt[2]    <= peak;
      cnt[3]    <= peak >> 1;
      rising    <= 4'b0011;
      zero_o    <= rst ? 4'b0000 : 4'b0001;
      irq_o     <= !rst;
    end else if (en) begin
      for (int k = 0; k < NC; k++) begin
        cnt[k] <= nxt[k];
        if (rising[k] && nxt[k] == pk) rising[k] <= 1'b0;
        if (!rising[k] && nxt[k] == '0) rising[k] <= 1'b1;
        zero_o[k] <= (nxt[k] == '0);
      end
      irq_o <= (nxt[0] == pk) || (nxt[0] == half) || (nxt[0] == '0);
    end else begin
      zero_o <= '0;
      irq_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/carrier_bank_chk.sv
module carrier_bank_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [W-1:0]   peak,
  input logic [4*W-1:0] carrier_o,
  input logic [3:0]     zero_o,
  input logic           irq_o
);
  logic [W-1:0] c0, c1, c2, c3;
  logic [W:0]   s02, s13;
  logic         past_ok;

  assign c0  = carrier_o[0 +: W];
  assign c1  = carrier_o[W +: W];
  assign c2  = carrier_o[2*W +: W];
  assign c3  = carrier_o[3*W +: W];
  assign s02 = {1'b0, c0} + {1'b0, c2};
  assign s13 = {1'b0, c1} + {1'b0, c3};

  always_ff @(posedge clk) past_ok <= !rst;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    en |=> (c0 == $past(c0) + 1'b1) || (c0 == $past(c0) - 1'b1)); // R2
  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> s02 == s13); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(carrier_o) && zero_o == 4'b0000 && !irq_o); // R4
  AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> $onehot0(zero_o)); // R5
  AST_ZERO_AT_0: assert property (@(posedge clk) disable iff (rst)
    zero_o[0] |-> c0 == '0); // R5
  AST_ZERO_AT_1: assert property (@(posedge clk) disable iff (rst)
    zero_o[1] |-> c1 == '0); // R5
  AST_ZERO_AT_2: assert property (@(posedge clk) disable iff (rst)
    zero_o[2] |-> c2 == '0); // R5
  AST_ZERO_AT_3: assert property (@(posedge clk) disable iff (rst)
    zero_o[3] |-> c3 == '0); // R5
  AST_IRQ_POINT: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (c0 == '0) || (c2 == '0) || (c0 == c2)); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R6
  AST_PEAK_DEFER: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !zero_o[0]) |-> $stable(s02)); // R7
  AST_PEAK_LEGAL: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> !peak[0] && peak >= W'(4) && peak != '1); // R8
endmodule

bind carrier_bank carrier_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .peak(peak),
  .carrier_o(carrier_o), .zero_o(zero_o), .irq_o(irq_o)
);

// File: tb/sim_carrier_bank.sv
module sim_carrier_bank;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           en  = 1'b0;
  logic [W-1:0]   peak = W'(8);
  logic [4*W-1:0] carrier_o;
  logic [3:0]     zero_o;
  logic           irq_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int ph = 0;
  int P = 8;
  bit valid = 0;
  bit [3:0] zexp = '0;
  bit iexp = 0;

  carrier_bank #(.W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .peak(peak),
    .carrier_o(carrier_o), .zero_o(zero_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  function automatic int tri_at(int x, int p);
    int m;
    m = x % (2 * p);
    return (m <= p) ? m : 2 * p - m;
  endfunction

  function automatic int chan(int k);
    return int'(carrier_o[k*W +: W]);
  endfunction

  task automatic check(string req, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  // Reference model: a phase index into an ideal triangle
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      P = int'(peak); ph = 0; zexp = '0; iexp = 0; valid = 1;
    end else if (en) begin
      ph = ph + 1;
      if (ph == 2 * P) begin
        ph = 0;
        P = int'(peak);
      end
      for (int k = 0; k < 4; k++) zexp[k] = (((ph + k * P / 2) % (2 * P)) == 0);
      iexp = ((ph % (P / 2)) == 0);
    end else begin
      zexp = '0; iexp = 0;
    end
  end

  always @(negedge clk) begin
    if (valid && !done) begin
      check("R2", "carrier0", chan(0), tri_at(ph, P));
      for (int k = 1; k < 4; k++)
        check("R3,R8", $sformatf("carrier%0d", k), chan(k), tri_at(ph + k * P / 2, P));
      check("R5", "zero strobes", int'(zero_o), int'(zexp));
      check("R6", "irq", int'(irq_o), int'(iexp));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(int p);
    @(negedge clk);
    rst = 1; peak = W'(p);
    cyc(2);
    check("R1", "reset carrier0", chan(0), 0);
    check("R1", "reset carrier1", chan(1), p / 2);
    check("R1", "reset carrier2", chan(2), p);
    check("R1", "reset carrier3", chan(3), p / 2);
    check("R1", "reset strobes", int'({zero_o, irq_o}), 0);
    rst = 0;
  endtask

  initial begin
    int snap;
    do_reset(8);
    en = 1;
    cyc(100);

    // stalls
    for (int i = 0; i < 300; i++) begin
      en = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    en = 0;
    cyc(1);
    snap = int'(carrier_o[W-1:0]);
    cyc(5);
    check("R4", "frozen carrier0", chan(0), snap);
    check("R4", "strobes low while frozen", int'({zero_o, irq_o}), 0);
    en = 1;

    // mid-period peak change, deferred until carrier 0 wraps
    while (chan(0) != 3) @(negedge clk);
    peak = W'(12);
    cyc(1);
    check("R7", "carrier2 keeps old peak mid-period", chan(0) + chan(2), 8);
    while (!zero_o[0]) @(negedge clk);
    check("R7", "carrier2 at new peak after wrap", chan(2), 12);
    check("R7", "carrier1 at new half after wrap", chan(1), 6);
    cyc(200);

    // change just before wrap, with stalls
    while (!(chan(0) == 1 && chan(2) == 11)) @(negedge clk);
    peak = W'(4);
    cyc(40);
    for (int i = 0; i < 200; i++) begin
      en = ($urandom_range(0, 2) != 0);
      @(negedge clk);
    end
    en = 1;

    peak = W'(254);
    cyc(1200);

    do_reset(10);
    en = 1;
    cyc(150);
    peak = W'(6);
    for (int i = 0; i < 300; i++) begin
      en = ($urandom_range(0, 4) != 0);
      @(negedge clk);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule